// File: doc/BRIEF.md
# Dual-Mode Serial Register Slave

This block is the host-facing serial port of a timekeeping peripheral. It runs on the chip's system clock. It oversamples chip enable, serial clock and serial data, then turns each transfer into accesses on a simple register-side bus. The 128 offsets on that bus hold the clock registers (low offsets) and user RAM (from a parameterised base upward). The register file sits outside this block.

A mode input chooses between two framings. In four-wire mode there are separate data in and data out lines, and bytes travel most significant bit first. The clock polarity is taken from the serial clock level at the moment chip enable rises. In three-wire mode one shared line carries both directions, and bytes travel least significant bit first. Every transfer opens with an address byte. Its top bit selects write (1) or read (0). One or more data bytes follow, and the offset steps forward after each one, wrapping inside its region.

When a read begins, the block pulses a capture strobe so that the register file can freeze a copy of the running time. A burst read then returns a consistent snapshot. The block also enforces the reserved window and the write-protect rule before it issues any write.

Top module: `rsl_serial_slave`

## Requirements
- R1: With `mode_spi`=1, address and data bytes are taken in and sent out most significant bit first. With `mode_spi`=0, both directions are least significant bit first.
- R2: The first byte after `ce` rises is the address. Bit 7 = 1 opens a write and bit 7 = 0 opens a read. Bits 6..0 give the starting offset, which is presented on `reg_addr`.
- R3: In four-wire mode, if `sclk` is low when `ce` rises, input is sampled on falling edges and output changes on rising edges. If `sclk` is high, the edges swap. In three-wire mode, input is sampled on rising edges and output changes on falling edges.
- R4: `sdo_oe` stays 0 through the address byte and until the first read bit is driven. It returns to 0 once `ce` is low.
- R5: After each data byte the offset increments. Offset 0x1F wraps to 0x00 and offset 0x7F wraps to 0x20, for reads and writes alike.
- R6: A write is issued only when the eighth bit of a data byte arrives. If `ce` falls earlier, that byte produces no `reg_we`.
- R7: `snap_capture` pulses for one clock exactly once per read transfer, when its address byte completes. Write transfers produce no pulse.
- R8: Offsets 0x12 to 0x1F read as 0x00, and writes to them produce no `reg_we`.
- R9: With `wp_in`=1, a write to offset 0x0F issues `reg_we` with `reg_wmask`=0x40 (bit 6 only), and writes to every other offset issue nothing. With `wp_in`=0, `reg_wmask`=0xFF.
- R10: Each accepted data byte gives a single-clock `reg_we` pulse. In that cycle `reg_addr` shows the target offset and `reg_wdata` shows the received byte.
- R11: When `ce` falls, the bit count and the state are cleared, so the next transfer begins again with an address byte, whatever was cut off before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_spi | input | 1 | 1 selects four-wire framing, 0 selects three-wire framing |
| ce | input | 1 | Chip enable, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in (the shared line in three-wire mode) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| wp_in | input | 1 | Current write-protect bit from the register file |
| reg_rdata | input | 8 | Read data for the offset on `reg_addr` |
| reg_addr | output | 7 | Register-side offset |
| reg_we | output | 1 | Write strobe, one clock wide |
| reg_wdata | output | 8 | Write data |
| reg_wmask | output | 8 | Bit-enable mask for the write |
| snap_capture | output | 1 | Pulse asking the register file to freeze its time copy |

## Verification
The hardest cases to reach from the ports are a burst that runs across a region boundary and a write byte that is cut short. A burst across 0x1F or 0x7F needs the right start offset together with a long enough burst. A cut-short write needs `ce` to fall part-way through a data byte, after the address has already been accepted. The stimulus places these on purpose in both framings and at both polarities. The random transfers also pull their start offsets toward the boundary, control and reserved offsets, so that wraps, masked writes and reserved reads keep recurring under every edge arrangement.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  localparam int RSL_BYTE_W = 8;
  localparam int RSL_OFF_W  = 7;
  localparam int RSL_CNT_W  = $clog2(RSL_BYTE_W);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WDATA, ST_RDATA} rsl_state_e;

  // Reverse bit order, used to turn LSB-first framing into a MSB-first shift.
  function automatic logic [RSL_BYTE_W-1:0] rsl_bitrev(input logic [RSL_BYTE_W-1:0] b);
    logic [RSL_BYTE_W-1:0] r;
    for (int i = 0; i < RSL_BYTE_W; i++) r[i] = b[RSL_BYTE_W-1-i];
    return r;
  endfunction

  // Accumulate one received bit according to the framing order.
  function automatic logic [RSL_BYTE_W-1:0] rsl_shift_in(input logic [RSL_BYTE_W-1:0] acc,
                                                         input logic b, input logic lsb_first);
    return lsb_first ? {b, acc[RSL_BYTE_W-1:1]} : {acc[RSL_BYTE_W-2:0], b};
  endfunction

  function automatic logic rsl_in_span(input logic [RSL_OFF_W-1:0] off,
                                       input logic [RSL_OFF_W-1:0] lo,
                                       input logic [RSL_OFF_W-1:0] hi);
    return (off >= lo) && (off <= hi);
  endfunction

  // Burst step: clock region wraps to zero, RAM region wraps to its base.
  function automatic logic [RSL_OFF_W-1:0] rsl_next_off(input logic [RSL_OFF_W-1:0] off,
                                                        input logic [RSL_OFF_W-1:0] ram_base);
    if (off == ram_base - 1'b1) return '0;
    if (off == '1) return ram_base;
    return off + 1'b1;
  endfunction

  // Bits a write may touch; zero means the write is dropped.
  function automatic logic [RSL_BYTE_W-1:0] rsl_wmask(input logic [RSL_OFF_W-1:0] off,
                                                      input logic wp,
                                                      input logic [RSL_OFF_W-1:0] lo,
                                                      input logic [RSL_OFF_W-1:0] hi,
                                                      input logic [RSL_OFF_W-1:0] ctrl,
                                                      input int wp_bit);
    if (rsl_in_span(off, lo, hi)) return '0;
    if (!wp) return '1;
    if (off == ctrl) return RSL_BYTE_W'(1) << wp_bit;
    return '0;
  endfunction
endpackage

// File: rtl/rsl_sync.sv
module rsl_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  localparam int CHAIN_W = N * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-N-1:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[CHAIN_W-1 -: N];
endmodule

// File: rtl/rsl_engine.sv
module rsl_engine
  import rsl_pkg::*;
#(
  parameter logic [RSL_OFF_W-1:0] RAM_BASE = 7'h20,
  parameter logic [RSL_OFF_W-1:0] RSV_LO   = 7'h12,
  parameter logic [RSL_OFF_W-1:0] RSV_HI   = 7'h1F,
  parameter logic [RSL_OFF_W-1:0] CTRL_OFF = 7'h0F,
  parameter int                   WP_BIT   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_spi,
  input  logic                  ce_s,
  input  logic                  sclk_s,
  input  logic                  sdi_s,
  input  logic                  wp_in,
  input  logic [RSL_BYTE_W-1:0] reg_rdata,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic [RSL_OFF_W-1:0]  reg_addr,
  output logic                  reg_we,
  output logic [RSL_BYTE_W-1:0] reg_wdata,
  output logic [RSL_BYTE_W-1:0] reg_wmask,
  output logic                  snap_capture
);
  rsl_state_e             st_q;
  logic                   ce_p_q, sclk_p_q;
  logic                   cpol_q, mode_q;
  logic [RSL_CNT_W-1:0]   bitcnt_q;
  logic [RSL_BYTE_W-1:0]  rx_q, tx_q, wdata_q, wmask_q;
  logic [RSL_OFF_W-1:0]   cur_off_q;
  logic                   sdo_q, oe_q, we_q, snap_q, inc_q, load_q;

  // Named internal events.
  logic                   ce_rise, sclk_rise, sclk_fall, latch_on_rise;
  logic                   latch_ev, shift_ev, byte_done;
  logic [RSL_BYTE_W-1:0]  rx_next, rdata_eff, wr_mask_now;

  assign ce_rise       = ce_s & ~ce_p_q;
  assign sclk_rise     = sclk_s & ~sclk_p_q;
  assign sclk_fall     = ~sclk_s & sclk_p_q;
  assign latch_on_rise = mode_q ? cpol_q : 1'b1;
  assign latch_ev      = ce_s & ~ce_rise & (latch_on_rise ? sclk_rise : sclk_fall);
  assign shift_ev      = ce_s & ~ce_rise & (latch_on_rise ? sclk_fall : sclk_rise);
  assign byte_done     = latch_ev & (bitcnt_q == RSL_CNT_W'(RSL_BYTE_W-1));
  assign rx_next       = rsl_shift_in(rx_q, sdi_s, ~mode_q);
  assign rdata_eff     = rsl_in_span(cur_off_q, RSV_LO, RSV_HI) ? '0 : reg_rdata;
  assign wr_mask_now   = rsl_wmask(cur_off_q, wp_in, RSV_LO, RSV_HI, CTRL_OFF, WP_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_p_q   <= 1'b0;
      sclk_p_q <= 1'b0;
    end else begin
      ce_p_q   <= ce_s;
      sclk_p_q <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cpol_q    <= 1'b0;
      mode_q    <= 1'b1;
      bitcnt_q  <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      wdata_q   <= '0;
      wmask_q   <= '0;
      cur_off_q <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      snap_q    <= 1'b0;
      inc_q     <= 1'b0;
      load_q    <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      snap_q <= 1'b0;
      inc_q  <= 1'b0;
      load_q <= 1'b0;
      if (inc_q) cur_off_q <= rsl_next_off(cur_off_q, RAM_BASE);
      if (inc_q && st_q == ST_RDATA) load_q <= 1'b1;
      if (load_q) tx_q <= mode_q ? rdata_eff : rsl_bitrev(rdata_eff);
      if (!ce_s) begin
        st_q     <= ST_IDLE;
        bitcnt_q <= '0;
        oe_q     <= 1'b0;
      end else if (ce_rise) begin
        st_q     <= ST_ADDR;
        bitcnt_q <= '0;
        cpol_q   <= sclk_s;
        mode_q   <= mode_spi;
        oe_q     <= 1'b0;
      end else begin
        if (latch_ev) begin
          rx_q     <= rx_next;
          bitcnt_q <= bitcnt_q + 1'b1;
        end
        if (byte_done) begin
          case (st_q)
            ST_ADDR: begin
              cur_off_q <= rx_next[RSL_OFF_W-1:0];
              if (rx_next[RSL_BYTE_W-1]) begin
                st_q <= ST_WDATA;
              end else begin
                st_q   <= ST_RDATA;
                load_q <= 1'b1;
                snap_q <= 1'b1;
              end
            end
            ST_WDATA: begin
              we_q    <= |wr_mask_now;
              wdata_q <= rx_next;
              wmask_q <= wr_mask_now;
              inc_q   <= 1'b1;
            end
            ST_RDATA: inc_q <= 1'b1;
            default: ;
          endcase
        end
        if (shift_ev && st_q == ST_RDATA) begin
          sdo_q <= tx_q[RSL_BYTE_W-1];
          tx_q  <= {tx_q[RSL_BYTE_W-2:0], 1'b0};
          oe_q  <= 1'b1;
        end
      end
    end
  end

  assign sdo          = sdo_q;
  assign sdo_oe       = oe_q;
  assign reg_addr     = cur_off_q;
  assign reg_we       = we_q;
  assign reg_wdata    = wdata_q;
  assign reg_wmask    = wmask_q;
  assign snap_capture = snap_q;

  a_r4_oe_drops_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sdo_oe);
  a_r4_oe_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> st_q == ST_RDATA);
  a_r6_write_after_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(byte_done));
  a_r10_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r7_snap_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    snap_capture |=> !snap_capture);
  a_r8_no_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !(reg_addr >= RSV_LO && reg_addr <= RSV_HI));
  a_r9_protected_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && $past(wp_in)) |-> (reg_addr == CTRL_OFF &&
                                  reg_wmask == (RSL_BYTE_W'(1) << WP_BIT)));
  a_r5_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
    inc_q |=> ((cur_off_q < RAM_BASE) == ($past(cur_off_q) < RAM_BASE)));
endmodule

// File: rtl/rsl_serial_slave.sv
module rsl_serial_slave
  import rsl_pkg::*;
#(
  parameter int                   SYNC_STAGES = 2,
  parameter logic [RSL_OFF_W-1:0] RAM_BASE    = 7'h20,
  parameter logic [RSL_OFF_W-1:0] RSV_LO      = 7'h12,
  parameter logic [RSL_OFF_W-1:0] RSV_HI      = 7'h1F,
  parameter logic [RSL_OFF_W-1:0] CTRL_OFF    = 7'h0F,
  parameter int                   WP_BIT      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_spi,
  input  logic                  ce,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic                  wp_in,
  input  logic [RSL_BYTE_W-1:0] reg_rdata,
  output logic [RSL_OFF_W-1:0]  reg_addr,
  output logic                  reg_we,
  output logic [RSL_BYTE_W-1:0] reg_wdata,
  output logic [RSL_BYTE_W-1:0] reg_wmask,
  output logic                  snap_capture
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pins_sync;

  rsl_sync #(.N(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ce, sclk, sdi}),
    .sync_o  (pins_sync)
  );

  rsl_engine #(
    .RAM_BASE (RAM_BASE),
    .RSV_LO   (RSV_LO),
    .RSV_HI   (RSV_HI),
    .CTRL_OFF (CTRL_OFF),
    .WP_BIT   (WP_BIT)
  ) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_spi     (mode_spi),
    .ce_s         (pins_sync[2]),
    .sclk_s       (pins_sync[1]),
    .sdi_s        (pins_sync[0]),
    .wp_in        (wp_in),
    .reg_rdata    (reg_rdata),
    .sdo          (sdo),
    .sdo_oe       (sdo_oe),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_wmask    (reg_wmask),
    .snap_capture (snap_capture)
  );
endmodule

// File: tb/rsl_serial_slave_tb_top.sv
`timescale 1ns/1ps
module rsl_serial_slave_tb_top;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic mode_spi = 1'b1, ce = 1'b0, sclk = 1'b0, m_data = 1'b0, wp = 1'b0;
  logic sdo, sdo_oe, reg_we, snap_capture;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_wmask;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [7:0] wbuf [8];
  wire  sdi_w = (!mode_spi && sdo_oe) ? sdo : m_data;
  wire [7:0] reg_rdata = mem[reg_addr];

  int n_checks = 0, n_err = 0, we_cnt = 0, snap_cnt = 0;
  bit done = 0;

  rsl_serial_slave dut_i (
    .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi), .ce(ce), .sclk(sclk), .sdi(sdi_w),
    .sdo(sdo), .sdo_oe(sdo_oe), .wp_in(wp), .reg_rdata(reg_rdata), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .snap_capture(snap_capture)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 2));
  endfunction

  // Register file model driven only through the block's bus.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] <= (mem[reg_addr] & ~reg_wmask) | (reg_wdata & reg_wmask);
    end
  end
  always @(posedge clk) begin
    if (rst_n && reg_we) we_cnt <= we_cnt + 1;
    if (rst_n && snap_capture) snap_cnt <= snap_cnt + 1;
  end

  function automatic bit f_rsv(input logic [6:0] o);
    return (o >= 7'h12) && (o <= 7'h1F);
  endfunction
  function automatic logic [6:0] f_next(input logic [6:0] o);
    if (o < 7'h20) return (o + 7'd1) & 7'h1F;
    return (o == 7'h7F) ? 7'h20 : o + 7'd1;
  endfunction
  function automatic logic [7:0] f_mask(input logic [6:0] o, input logic p);
    if (f_rsv(o)) return 8'h00;
    if (!p) return 8'hFF;
    return (o == 7'h0F) ? 8'h40 : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic got, output logic oe_seen);
    if (mode_spi) begin
      sclk = ~sclk; m_data = b; waitc(HP);
      got = sdo; oe_seen = sdo_oe;
      sclk = ~sclk; waitc(HP);
    end else begin
      m_data = b; waitc(HP);
      got = sdo; oe_seen = sdo_oe;
      sclk = 1'b1; waitc(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] ob, output logic [7:0] ib,
                       output logic all_oe, output logic any_oe);
    all_oe = 1'b1; any_oe = 1'b0; ib = '0;
    for (int i = 0; i < 8; i++) begin
      int k;
      logic g, o;
      k = mode_spi ? 7 - i : i;
      xbit(ob[k], g, o);
      ib[k] = g; all_oe &= o; any_oe |= o;
    end
  endtask

  task automatic t_begin(input logic spi, input logic cpol);
    mode_spi = spi;
    sclk = spi ? cpol : 1'b0;
    waitc(HP);
    ce = 1'b1;
    waitc(HP);
  endtask

  task automatic t_end();
    ce = 1'b0;
    waitc(2 * HP);
    chk(sdo_oe == 1'b0, "R4 oe low after ce", sdo_oe, 0);
  endtask

  task automatic map_check(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < 128; i++) if (mem[i] !== exp_mem[i] && bad < 0) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(mem[bad]), int'(exp_mem[bad]));
  endtask

  task automatic t_read(input logic spi, input logic cpol, input logic [6:0] off, input int n);
    logic [7:0] got, ev;
    logic all_oe, any_oe;
    logic [6:0] a;
    int s0;
    s0 = snap_cnt;
    t_begin(spi, cpol);
    xbyte({1'b0, off}, got, all_oe, any_oe);
    chk(any_oe == 1'b0, "R4 oe low in address byte", any_oe, 0);
    a = off;
    for (int j = 0; j < n; j++) begin
      xbyte(8'h00, got, all_oe, any_oe);
      ev = f_rsv(a) ? 8'h00 : exp_mem[a];
      chk(got == ev, "R1 R2 R3 R5 R8 read byte", got, ev);
      chk(all_oe == 1'b1, "R4 oe high in read data", all_oe, 1);
      a = f_next(a);
    end
    t_end();
    chk(snap_cnt == s0 + 1, "R7 one snapshot per read", snap_cnt - s0, 1);
  endtask

  task automatic t_write(input logic spi, input logic cpol, input logic [6:0] off, input int n);
    logic [7:0] got, m;
    logic all_oe, any_oe;
    logic [6:0] a;
    int w0, s0, ew;
    w0 = we_cnt; s0 = snap_cnt; ew = 0;
    t_begin(spi, cpol);
    xbyte({1'b1, off}, got, all_oe, any_oe);
    a = off;
    for (int j = 0; j < n; j++) begin
      xbyte(wbuf[j], got, all_oe, any_oe);
      chk(any_oe == 1'b0, "R4 oe low in write", any_oe, 0);
      m = f_mask(a, wp);
      if (m != 8'h00) ew++;
      exp_mem[a] = (exp_mem[a] & ~m) | (wbuf[j] & m);
      a = f_next(a);
    end
    t_end();
    chk(we_cnt - w0 == ew, "R10 R9 R8 write pulse count", we_cnt - w0, ew);
    chk(snap_cnt == s0, "R7 no snapshot on write", snap_cnt - s0, 0);
    map_check("R1 R2 R5 R9 R10 map after write");
  endtask

  // CE drops after five bits of a data byte.
  task automatic t_abort(input logic spi, input logic cpol, input logic [6:0] off);
    logic [7:0] got;
    logic all_oe, any_oe, g, o;
    int w0;
    w0 = we_cnt;
    t_begin(spi, cpol);
    xbyte({1'b1, off}, got, all_oe, any_oe);
    for (int i = 0; i < 5; i++) xbit(1'b1, g, o);
    ce = 1'b0;
    sclk = spi ? cpol : 1'b0;
    waitc(2 * HP);
    chk(we_cnt == w0, "R6 aborted byte not written", we_cnt - w0, 0);
    map_check("R6 map unchanged after abort");
  endtask

  initial begin
    int seed_d;
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    seed_d = $urandom(32'd20240611);
    waitc(5);
    rst_n = 1'b1;
    waitc(4);
    chk(sdo_oe == 1'b0, "R4 reset oe", sdo_oe, 0);
    chk(reg_we == 1'b0, "R10 reset we", reg_we, 0);
    chk(snap_capture == 1'b0, "R7 reset snap", snap_capture, 0);

    // Directed corner cases.
    t_read(1'b1, 1'b0, 7'h1E, 3);
    t_read(1'b1, 1'b1, 7'h7E, 3);
    t_read(1'b0, 1'b0, 7'h05, 2);
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
    t_write(1'b0, 1'b0, 7'h7E, 3);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    t_write(1'b1, 1'b1, 7'h1F, 3);
    wbuf[0] = 8'h5A; wbuf[1] = 8'h66;
    t_write(1'b1, 1'b0, 7'h10, 2);
    wp = 1'b1;
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    t_write(1'b1, 1'b0, 7'h0F, 2);
    wbuf[0] = 8'h00;
    t_write(1'b0, 1'b0, 7'h0F, 1);
    wp = 1'b0;
    t_abort(1'b1, 1'b0, 7'h40);
    t_read(1'b1, 1'b0, 7'h40, 1);
    t_abort(1'b0, 1'b0, 7'h41);
    t_read(1'b0, 1'b0, 7'h41, 2);

    // Random transfers, offsets pulled toward boundaries.
    for (int t = 0; t < 24; t++) begin
      logic spi, cpol, rw;
      logic [6:0] off;
      int n, sel;
      spi = 1'($urandom % 2);
      cpol = 1'($urandom % 2);
      rw = 1'($urandom % 2);
      off = 7'($urandom % 128);
      sel = $urandom % 6;
      if (sel == 0) off = 7'h1E;
      else if (sel == 1) off = 7'h7F;
      else if (sel == 2) off = 7'h0F;
      n = 1 + ($urandom % 4);
      wp = ($urandom % 6) == 0;
      if (rw) begin
        for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
        t_write(spi, cpol, off, n);
      end else begin
        t_read(spi, cpol, off, n);
      end
    end
    wp = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog R11 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule